// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds or subtracts two 64-bit packed operands as a set of independent lanes. A two-bit lane-size select splits the datapath into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Carries never cross a lane boundary, so each lane computes exactly what a scalar adder of that width would compute.

Two further controls pick the overflow behaviour. In wrap mode each lane keeps the low bits of its result. In saturating mode a lane whose result does not fit is clamped to the nearest representable value. The clamp follows the signed or unsigned range, as a third control selects. Overflow never produces an exception: a result is always delivered. A per-lane flag vector reports which lanes clamped in the current operation.

The result, the flags and a valid bit are registered once, so an operation presented with `in_valid` appears on the outputs in the following cycle.

Top module: `simd_sat_adder`

## Requirements
- R1: `mode` selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes, 3 gives one 64-bit lane. Lane k occupies bits [k*w +: w] of `a`, `b` and `result`, where w is the lane width.
- R2: With `sat_en` low and `sub` low, each lane of `result` equals (a_lane + b_lane) mod 2^w. No lane depends on any other lane.
- R3: With `sat_en` low and `sub` high, each lane of `result` equals (a_lane - b_lane) mod 2^w. The borrow is formed inside each lane.
- R4: With `sat_en` and `is_signed` high, lanes are two's complement. A sum or difference above 2^(w-1)-1 yields 2^(w-1)-1, and one below -2^(w-1) yields -2^(w-1). Any other result is exact.
- R5: With `sat_en` high and `is_signed` low, lanes are unsigned. An add above 2^w-1 yields 2^w-1, and a subtract below zero yields zero. Any other result is exact.
- R6: In saturating mode, bit k of `sat_flags` is 1 exactly when lane k was clamped. Bits at or above the lane count (8, 4, 2 or 1) are 0.
- R7: With `sat_en` low, every bit of `sat_flags` is 0, whatever the operands.
- R8: `out_valid` equals `in_valid` from the previous cycle. `result` and `sat_flags` are loaded only in a cycle with `in_valid` high, and otherwise keep their value.
- R9: While `rst_n` is low, `out_valid`, `result` and `sat_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | Lane width select (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| sat_en | input | 1 | 1: saturating arithmetic, 0: wrap-around |
| is_signed | input | 1 | 1: lanes are two's complement, 0: unsigned (saturating mode only) |
| sub | input | 1 | 1: a - b, 0: a + b |
| a | input | 64 | Packed first operand |
| b | input | 64 | Packed second operand |
| out_valid | output | 1 | Registered result is from a valid operation |
| result | output | 64 | Packed registered result |
| sat_flags | output | 8 | Per-lane clamp flags, bit k for lane k |

## Verification
The sweeps place corner values in every lane in every mode: zero, one, the signed maximum and minimum, their neighbours and all-ones. The corner values are rotated so that a lane at a boundary sits beside lanes that overflow differently. A carry that leaks across a boundary, or a carry-in injected only at bit 0 during subtraction, corrupts the lane above the first one. A design that clamps signed overflow with unsigned rules, or saturates an unsigned subtract to all-ones instead of zero, returns the wrong extreme. Flags misplaced in wide modes, or raised in wrap mode, show up as nonzero unused bits. A result register that loads while `in_valid` is low changes during idle cycles.

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int LANE_BITS = 8,
  parameter int SLOTS     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 mode,
  input  logic                       sat_en,
  input  logic                       is_signed,
  input  logic                       sub,
  input  logic [LANE_BITS*SLOTS-1:0] a,
  input  logic [LANE_BITS*SLOTS-1:0] b,
  output logic                       out_valid,
  output logic [LANE_BITS*SLOTS-1:0] result,
  output logic [SLOTS-1:0]           sat_flags
);
  localparam int W = LANE_BITS * SLOTS;
  localparam int L = LANE_BITS;

  logic [W-1:0]     bx;
  logic [W-1:0]     sum;
  logic [W-1:0]     nxt;
  logic [SLOTS:0]   c;
  logic [SLOTS-1:0] nflags;

  assign bx = sub ? ~b : b;

  always_comb begin
    int seg;
    seg  = 1 << mode;
    c[0] = sub;
    sum  = '0;
    for (int j = 0; j < SLOTS; j++) begin
      logic cin;
      cin = ((j & (seg - 1)) == 0) ? sub : c[j];
      {c[j+1], sum[j*L +: L]} = {1'b0, a[j*L +: L]} + {1'b0, bx[j*L +: L]} + {{L{1'b0}}, cin};
    end
  end

  always_comb begin
    int seg;
    seg    = 1 << mode;
    nxt    = sum;
    nflags = '0;
    for (int j = 0; j < SLOTS; j++) begin
      int   top;
      logic am, bm, sm, clamp, hi;
      top = j | (seg - 1);
      am  = a[top*L + L - 1];
      bm  = bx[top*L + L - 1];
      sm  = sum[top*L + L - 1];
      if (is_signed) begin
        clamp = (am == bm) && (sm != am);
        hi    = !am;
      end else begin
        clamp = sub ? !c[top+1] : c[top+1];
        hi    = !sub;
      end
      clamp = clamp && sat_en;
      if (clamp) begin
        if (hi) nxt[j*L +: L] = (is_signed && j == top) ? {1'b0, {(L-1){1'b1}}} : {L{1'b1}};
        else    nxt[j*L +: L] = (is_signed && j == top) ? {1'b1, {(L-1){1'b0}}} : {L{1'b0}};
        nflags[j >> mode] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt;
        sat_flags <= nflags;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(sat_flags))); // R8
  AST_WRAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en) |=> (sat_flags == '0)); // R7
  AST_WIDE_FLAG_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3) |=> (sat_flags[SLOTS-1:1] == '0)); // R6
  AST_USAT_ADD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && !is_signed && !sub && mode == 2'd3) |=> (result >= $past(a))); // R5
  AST_USAT_SUB_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && !is_signed && sub && mode == 2'd3) |=> (result <= $past(a))); // R5
endmodule

// File: tb/simd_sat_adder_tb.sv
module simd_sat_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  mode;
  logic        sat_en, is_signed, sub;
  logic [63:0] a, b;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  sat_flags;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  simd_sat_adder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .sat_en(sat_en), .is_signed(is_signed), .sub(sub), .a(a), .b(b),
    .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
  );

  // Lane arithmetic done in 66 bits, per requirements R1..R7
  function automatic logic [71:0] model(input logic [1:0] md, input logic st, input logic sg,
                                        input logic sb, input logic [63:0] x, input logic [63:0] y);
    int n, w;
    logic [63:0] r;
    logic [7:0] f;
    n = 8 >> md;
    w = 8 << md;
    r = '0;
    f = '0;
    for (int k = 0; k < n; k++) begin
      logic signed [65:0] xv, yv, s, mx, mn;
      logic [63:0] lane;
      xv = 66'(x >> (k*w));
      yv = 66'(y >> (k*w));
      if (w < 64) begin
        xv = xv & ((66'sd1 <<< w) - 1);
        yv = yv & ((66'sd1 <<< w) - 1);
      end else begin
        xv = xv & {2'b00, {64{1'b1}}};
        yv = yv & {2'b00, {64{1'b1}}};
      end
      if (sg && st) begin
        if (xv[w-1]) xv = xv - (66'sd1 <<< w);
        if (yv[w-1]) yv = yv - (66'sd1 <<< w);
        mx = (66'sd1 <<< (w-1)) - 1;
        mn = -(66'sd1 <<< (w-1));
      end else begin
        mx = (66'sd1 <<< w) - 1;
        mn = 66'sd0;
      end
      s = sb ? xv - yv : xv + yv;
      if (st && s > mx) begin s = mx; f[k] = 1'b1; end
      if (st && s < mn) begin s = mn; f[k] = 1'b1; end
      lane = s[63:0];
      if (w < 64) lane = lane & ((64'd1 << w) - 1);
      r = r | (lane << (k*w));
    end
    return {f, r};
  endfunction

  function automatic logic [63:0] corner(input int idx, input int w);
    logic [63:0] m;
    m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 1);
    case (idx % 8)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'd2;
      3: return (m >> 1) - 1;
      4: return m >> 1;
      5: return (m >> 1) + 1;
      6: return m - 1;
      default: return m;
    endcase
  endfunction

  task automatic apply(input logic [1:0] md, input logic st, input logic sg, input logic sb,
                       input logic [63:0] x, input logic [63:0] y);
    logic [71:0] exp;
    string tag;
    mode = md; sat_en = st; is_signed = sg; sub = sb; a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(md, st, sg, sb, x, y);
    vectors++;
    if (st) tag = sg ? "R4" : "R5";
    else    tag = sb ? "R3" : "R2";
    if (!out_valid || result !== exp[63:0]) begin
      errors++;
      $display("FAIL %s/R1 mode=%0d sat=%0d sgn=%0d sub=%0d a=%h b=%h: got %h v=%0d, expected %h",
               tag, md, st, sg, sb, x, y, result, out_valid, exp[63:0]);
    end
    if (sat_flags !== exp[71:64]) begin
      errors++;
      $display("FAIL %s mode=%0d a=%h b=%h: flags %b, expected %b",
               st ? "R6" : "R7", md, x, y, sat_flags, exp[71:64]);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = '0; sat_en = 1'b0; is_signed = 1'b0; sub = 1'b0;
    a = '0; b = '0;
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || result !== 64'd0 || sat_flags !== 8'd0) begin
      errors++;
      $display("FAIL R9 reset: v=%0d r=%h f=%b, expected 0 0 0", out_valid, result, sat_flags);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int md = 0; md < 4; md++)
      for (int op = 0; op < 8; op++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            int w, n;
            logic [63:0] x, y;
            w = 8 << md; n = 8 >> md; x = '0; y = '0;
            for (int k = 0; k < n; k++) begin
              x = x | (corner(i + k, w) << (k*w));
              y = y | (corner(j + 3*k, w) << (k*w));
            end
            apply(2'(md), op[2], op[1], op[0], x, y);
          end

    for (int t = 0; t < 4000; t++)
      apply(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom});

    // R8: idle cycles leave outputs untouched
    apply(2'd0, 1'b1, 1'b1, 1'b0, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101);
    for (int t = 0; t < 3; t++) begin
      mode = 2'd3; sat_en = 1'b0; sub = 1'b1; a = 64'h1234; b = 64'h99; in_valid = 1'b0;
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0 || result !== 64'h7F7F_7F7F_7F7F_7F7F || sat_flags !== 8'hFF) begin
        errors++;
        $display("FAIL R8 hold: v=%0d r=%h f=%b, expected 0 7f7f7f7f7f7f7f7f 11111111",
                 out_valid, result, sat_flags);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule